// File: doc/BRIEF.md
# Configurable SEC-DED Flow-Through Memory EDAC

This block sits in the data path between a processor and a 16-bit memory that stores a check word next to every data word. On the write side it turns the outgoing 16 data bits into a check word. A static configuration input selects the check-word width: 6 bits, which gives a 22-bit stored word, or 8 bits, which gives a 24-bit stored word. On the read side it recomputes the check bits from the returned data and XORs them with the returned check word to form a syndrome. From the syndrome it classifies the access as clean, correctable or uncorrectable.

A second static input selects the repair policy. In correct mode a single failing data bit is inverted before the word is driven out. In detect mode the received data always passes through untouched, and only the two flags and the exposed syndrome report the fault, so that software can analyse it. The code has odd-weight columns, which gives single-error correction and double-error detection. Its columns are placed so that any fault confined to one 4-bit memory device (6-bit option), or to one 4-bit or 8-bit device (8-bit option), always gives a nonzero syndrome. The datapath is combinational. A parameter adds one output register stage, which is present by default.

Top module: `edac_flow`

## Requirements
- R1: With `cfg_wide`=0 the check word has 6 bits on `wr_chk[5:0]`, `wr_chk[7:6]` reads 0, the stored word is {check[5:0], data[15:0]} (22 bits), and `rd_chk[7:6]` has no effect. With `cfg_wide`=1 all 8 check bits are used, and the stored word is {check[7:0], data[15:0]} (24 bits).
- R2: A word read back with the check word that the block produced for it gives syndrome 0, both flags low, and `rd_fixed` equal to the data.
- R3: Inverting any single bit of the stored word (data bit i at position i, check bit j at position 16+j) raises `flag_ce` with `flag_ue` low. In correct mode `rd_fixed` then equals the original data.
- R4: A single error in stored check bit j gives a syndrome with only bit j set.
- R5: Inverting any two distinct bits of the stored word raises `flag_ue` with `flag_ce` low, and `rd_fixed` equals the received data in both modes.
- R6: In detect mode (`cfg_correct`=0) `rd_fixed` always equals `rd_data`. The flags behave as they do in correct mode.
- R7: Any nonzero error pattern confined to stored bits [4k+3:4k] gives a nonzero syndrome and raises at least one flag. In the 6-bit option the last device is the 2 bits [21:20]. In the 8-bit option the same holds for any pattern confined to bits [8k+7:8k].
- R8: `flag_ce` and `flag_ue` are never high together. Syndrome 0 means both flags are low. A nonzero syndrome of even weight always raises `flag_ue`.
- R9: With the output register present, every output reflects the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 0: 6 check bits, 1: 8 check bits |
| cfg_correct | input | 1 | 1: correct single data-bit errors, 0: detect only |
| wr_data | input | 16 | Data going to memory |
| wr_chk | output | 8 | Check word to store beside `wr_data` |
| rd_data | input | 16 | Data returned by memory |
| rd_chk | input | 8 | Check word returned by memory |
| rd_fixed | output | 16 | Data towards the processor, repaired or raw |
| syndrome | output | 8 | Recomputed check XOR stored check |
| flag_ce | output | 1 | Correctable (single-bit) error |
| flag_ue | output | 1 | Uncorrectable error |

## Verification
With the default output register, every result is due one rising edge after the inputs that produce it. The bench drives each stimulus on a falling edge and reads the outputs at the next falling edge, half a period after the capturing edge. One probe reads the outputs 1 ns after a new word is driven and expects the previous result to still be shown. Each error pattern (every single position, every pair, every device pattern) is therefore applied for exactly one cycle and checked in that cycle, in both code widths and both repair modes.

// File: rtl/edac_cfg_pkg.sv
package edac_cfg_pkg;

    localparam int DATA_W     = 16;
    localparam int CHK_NARROW = 6;
    localparam int CHK_WIDE   = 8;
    localparam int SYN_W      = CHK_WIDE;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [SYN_W-1:0]  syn_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'd0,
        ERR_SINGLE = 2'd1,
        ERR_MULTI  = 2'd2
    } err_kind_e;

    typedef struct packed {
        data_t     data;
        syn_t      syn;
        err_kind_e kind;
    } rd_result_t;

    localparam syn_t NARROW_MASK = {{(SYN_W-CHK_NARROW){1'b0}}, {CHK_NARROW{1'b1}}};

    // 6-bit code: weight-3 column, rotation r of the offset set {0, 1, 2+g}
    function automatic syn_t col_narrow(int unsigned bit_idx);
        int unsigned r;
        int unsigned g;
        syn_t c;
        r = bit_idx % CHK_NARROW;
        g = bit_idx / CHK_NARROW;
        c = '0;
        c = c | (syn_t'(1) << r);
        c = c | (syn_t'(1) << ((r + 1) % CHK_NARROW));
        c = c | (syn_t'(1) << ((r + 2 + g) % CHK_NARROW));
        return c;
    endfunction

    // 8-bit code: weight-3 column, rotation r of the offset set {0, 1+g, 3}
    function automatic syn_t col_wide(int unsigned bit_idx);
        int unsigned r;
        int unsigned g;
        syn_t c;
        r = bit_idx % CHK_WIDE;
        g = bit_idx / CHK_WIDE;
        c = '0;
        c = c | (syn_t'(1) << r);
        c = c | (syn_t'(1) << ((r + 1 + g) % CHK_WIDE));
        c = c | (syn_t'(1) << ((r + 3) % CHK_WIDE));
        return c;
    endfunction

endpackage

// File: rtl/edac_parity_tree.sv
module edac_parity_tree
    import edac_cfg_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  data_t data,
    output syn_t  chk
);

    syn_t terms [DATA_W];

    for (genvar i = 0; i < DATA_W; i++) begin : g_term
        localparam syn_t COL = WIDE ? col_wide(i) : col_narrow(i);
        assign terms[i] = data[i] ? COL : '0;
    end

    always_comb begin
        chk = '0;
        for (int i = 0; i < DATA_W; i++) begin
            chk = chk ^ terms[i];
        end
    end

endmodule

// File: rtl/edac_col_match.sv
module edac_col_match
    import edac_cfg_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  syn_t  syn,
    output data_t data_hit,
    output logic  chk_hit
);

    localparam int CW = WIDE ? CHK_WIDE : CHK_NARROW;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cmp
        localparam syn_t COL = WIDE ? col_wide(i) : col_narrow(i);
        assign data_hit[i] = (syn == COL);
    end

    logic [CW-1:0] unit_hit;

    for (genvar j = 0; j < CW; j++) begin : g_unit
        assign unit_hit[j] = (syn == (syn_t'(1) << j));
    end

    assign chk_hit = |unit_hit;

endmodule

// File: rtl/edac_classify.sv
module edac_classify
    import edac_cfg_pkg::*;
(
    input  data_t      raw,
    input  syn_t       syn,
    input  data_t      data_hit,
    input  logic       chk_hit,
    input  logic       corr_en,
    output rd_result_t res
);

    err_kind_e kind;
    data_t     fix;

    always_comb begin
        if (syn == '0) begin
            kind = ERR_NONE;
        end else if ((^syn) && ((|data_hit) || chk_hit)) begin
            kind = ERR_SINGLE;
        end else begin
            kind = ERR_MULTI;
        end
        fix      = (corr_en && (kind == ERR_SINGLE)) ? data_hit : '0;
        res.data = raw ^ fix;
        res.syn  = syn;
        res.kind = kind;
    end

endmodule

// File: rtl/edac_flow.sv
module edac_flow
    import edac_cfg_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wide,
    input  logic              cfg_correct,
    input  logic [DATA_W-1:0] wr_data,
    output logic [SYN_W-1:0]  wr_chk,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [SYN_W-1:0]  rd_chk,
    output logic [DATA_W-1:0] rd_fixed,
    output logic [SYN_W-1:0]  syndrome,
    output logic              flag_ce,
    output logic              flag_ue
);

    // write path: both code variants, selected by configuration
    syn_t enc_n, enc_w, chk_d, chk_q;

    edac_parity_tree #(.WIDE(1'b0)) u_enc_n (.data(wr_data), .chk(enc_n));
    edac_parity_tree #(.WIDE(1'b1)) u_enc_w (.data(wr_data), .chk(enc_w));

    assign chk_d = cfg_wide ? enc_w : enc_n;

    // read path: recompute, form syndrome, locate
    syn_t re_n, re_w, syn_n, syn_w, syn_sel;

    edac_parity_tree #(.WIDE(1'b0)) u_re_n (.data(rd_data), .chk(re_n));
    edac_parity_tree #(.WIDE(1'b1)) u_re_w (.data(rd_data), .chk(re_w));

    assign syn_n   = (re_n ^ rd_chk) & NARROW_MASK;
    assign syn_w   = re_w ^ rd_chk;
    assign syn_sel = cfg_wide ? syn_w : syn_n;

    data_t hit_n, hit_w, hit_sel;
    logic  unit_n, unit_w, unit_sel;

    edac_col_match #(.WIDE(1'b0)) u_loc_n (.syn(syn_n), .data_hit(hit_n), .chk_hit(unit_n));
    edac_col_match #(.WIDE(1'b1)) u_loc_w (.syn(syn_w), .data_hit(hit_w), .chk_hit(unit_w));

    assign hit_sel  = cfg_wide ? hit_w  : hit_n;
    assign unit_sel = cfg_wide ? unit_w : unit_n;

    rd_result_t res_d, res_q;

    edac_classify u_cls (
        .raw      (rd_data),
        .syn      (syn_sel),
        .data_hit (hit_sel),
        .chk_hit  (unit_sel),
        .corr_en  (cfg_correct),
        .res      (res_d)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                res_q <= '0;
                chk_q <= '0;
            end else begin
                res_q <= res_d;
                chk_q <= chk_d;
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
        assign chk_q = chk_d;
    end

    assign wr_chk   = chk_q;
    assign rd_fixed = res_q.data;
    assign syndrome = res_q.syn;
    assign flag_ce  = (res_q.kind == ERR_SINGLE);
    assign flag_ue  = (res_q.kind == ERR_MULTI);

endmodule

// File: rtl/edac_flow_chk.sv
module edac_flow_chk
    import edac_cfg_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_wide,
    input logic              cfg_correct,
    input logic [DATA_W-1:0] rd_data,
    input logic [SYN_W-1:0]  wr_chk,
    input logic [DATA_W-1:0] rd_fixed,
    input logic [SYN_W-1:0]  syndrome,
    input logic              flag_ce,
    input logic              flag_ue
);

    data_t raw_v;
    logic  corr_v;
    logic  wide_v;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk) begin
            if (rst) begin
                raw_v  <= '0;
                corr_v <= 1'b0;
                wide_v <= 1'b0;
            end else begin
                raw_v  <= rd_data;
                corr_v <= cfg_correct;
                wide_v <= cfg_wide;
            end
        end
    end else begin : g_now
        assign raw_v  = rd_data;
        assign corr_v = cfg_correct;
        assign wide_v = cfg_wide;
    end

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(flag_ce && flag_ue));

    assert_zero_syn_clean_R2: assert property (@(posedge clk) disable iff (rst)
        (syndrome == '0) |-> (!flag_ce && !flag_ue && rd_fixed == raw_v));

    assert_nonzero_syn_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (syndrome != '0) |-> (flag_ce || flag_ue));

    assert_even_syn_uncorr_R5: assert property (@(posedge clk) disable iff (rst)
        ((syndrome != '0) && !(^syndrome)) |-> flag_ue);

    assert_detect_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        !corr_v |-> (rd_fixed == raw_v));

    assert_repair_one_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_fixed != raw_v) |-> (flag_ce && corr_v && $countones(rd_fixed ^ raw_v) == 1));

    assert_narrow_width_R1: assert property (@(posedge clk) disable iff (rst)
        !wide_v |-> (wr_chk[SYN_W-1:CHK_NARROW] == '0 && syndrome[SYN_W-1:CHK_NARROW] == '0));

endmodule

bind edac_flow edac_flow_chk #(.REG_OUT(REG_OUT)) u_flow_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_wide    (cfg_wide),
    .cfg_correct (cfg_correct),
    .rd_data     (rd_data),
    .wr_chk      (wr_chk),
    .rd_fixed    (rd_fixed),
    .syndrome    (syndrome),
    .flag_ce     (flag_ce),
    .flag_ue     (flag_ue)
);

// File: tb/test_edac_flow.sv
`timescale 1ns/1ps
module test_edac_flow;
    import edac_cfg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wide = 1'b0;
    logic        cfg_correct = 1'b1;
    logic [15:0] wr_data = '0;
    logic [7:0]  wr_chk;
    logic [15:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic [15:0] rd_fixed;
    logic [7:0]  syndrome;
    logic        flag_ce;
    logic        flag_ue;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1E87};

    always #2 clk = ~clk;

    edac_flow i_edac_flow (
        .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_correct(cfg_correct),
        .wr_data(wr_data), .wr_chk(wr_chk), .rd_data(rd_data), .rd_chk(rd_chk),
        .rd_fixed(rd_fixed), .syndrome(syndrome), .flag_ce(flag_ce), .flag_ue(flag_ue)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // encode: result due one edge after driving
    task automatic encode(input logic [15:0] d, input bit wide, output logic [7:0] c);
        @(negedge clk);
        cfg_wide = wide;
        wr_data  = d;
        @(negedge clk);
        c = wr_chk;
    endtask

    // present a stored word {chk, data} and wait for its result
    task automatic present(input logic [23:0] word, input bit wide, input bit corr);
        @(negedge clk);
        cfg_wide    = wide;
        cfg_correct = corr;
        rd_data     = word[15:0];
        rd_chk      = word[23:16];
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_wide = 1'b1;
        wr_data = 16'hBEEF;
        rd_data = 16'h1234;
        rd_chk  = 8'h5A;
        @(negedge clk);
        @(negedge clk);
        check(rd_fixed == '0 && syndrome == '0 && wr_chk == '0, "R9", "reset clears data/syn/chk",
              32'({rd_fixed, syndrome, wr_chk}), 32'h0);
        check(!flag_ce && !flag_ue, "R9", "reset clears flags", 32'({flag_ce, flag_ue}), 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_clean();
        logic [7:0] c;
        for (int w = 0; w < 2; w++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 4; k++) begin
                    encode(pats[k], w[0], c);
                    if (w == 0)
                        check(c[7:6] == 2'b00, "R1", "narrow check word upper bits",
                              32'(c), 32'(c & 8'h3F));
                    present({c, pats[k]}, w[0], m[0]);
                    check(syndrome == '0 && !flag_ce && !flag_ue, "R2", "clean word flags/syndrome",
                          32'({syndrome, flag_ce, flag_ue}), 32'h0);
                    check(rd_fixed == pats[k], "R2", "clean word data", 32'(rd_fixed), 32'(pats[k]));
                end
            end
        end
    endtask

    task automatic t_ignore_upper();
        logic [7:0] c;
        encode(16'h3C96, 1'b0, c);
        for (int u = 1; u < 4; u++) begin
            present({c ^ (8'(u) << 6), 16'h3C96}, 1'b0, 1'b1);
            check(!flag_ce && !flag_ue && syndrome == '0, "R1", "rd_chk[7:6] ignored in narrow mode",
                  32'({syndrome, flag_ce, flag_ue}), 32'h0);
            check(rd_fixed == 16'h3C96, "R1", "data unaffected by rd_chk[7:6]",
                  32'(rd_fixed), 32'h3C96);
        end
    endtask

    task automatic t_latency();
        logic [7:0] c;
        encode(16'h0F0F, 1'b1, c);
        present({c, 16'h0F0F}, 1'b1, 1'b1);
        @(negedge clk);
        rd_data = 16'h0F0E;
        #1;
        check(!flag_ce && rd_fixed == 16'h0F0F, "R9", "output holds before capturing edge",
              32'({flag_ce, rd_fixed}), 32'h0F0F);
        @(negedge clk);
        check(flag_ce && rd_fixed == 16'h0F0F, "R9", "result one edge after input",
              32'({flag_ce, rd_fixed}), 32'h10F0F);
    endtask

    task automatic t_single(input bit wide, input bit corr);
        logic [7:0]  c;
        logic [23:0] good, bad;
        int nbits;
        nbits = wide ? 24 : 22;
        for (int k = 0; k < 4; k++) begin
            encode(pats[k], wide, c);
            good = {c, pats[k]};
            for (int p = 0; p < nbits; p++) begin
                bad = good ^ (24'(1) << p);
                present(bad, wide, corr);
                check(flag_ce && !flag_ue, "R3", "single error flags",
                      32'({flag_ce, flag_ue}), 32'h2);
                if (corr)
                    check(rd_fixed == pats[k], "R3", "single error repaired",
                          32'(rd_fixed), 32'(pats[k]));
                else
                    check(rd_fixed == bad[15:0], "R6", "detect mode keeps raw data",
                          32'(rd_fixed), 32'(bad[15:0]));
                if (p >= 16)
                    check(syndrome == (8'(1) << (p - 16)), "R4", "check-bit error syndrome",
                          32'(syndrome), 32'(8'(1) << (p - 16)));
            end
        end
    endtask

    task automatic t_double(input bit wide, input bit corr);
        logic [7:0]  c;
        logic [23:0] good, bad;
        int nbits;
        nbits = wide ? 24 : 22;
        for (int k = 2; k < 4; k++) begin
            encode(pats[k], wide, c);
            good = {c, pats[k]};
            for (int a = 0; a < nbits; a++) begin
                for (int b = a + 1; b < nbits; b++) begin
                    bad = good ^ (24'(1) << a) ^ (24'(1) << b);
                    present(bad, wide, corr);
                    check(flag_ue && !flag_ce, "R5", "double error flags",
                          32'({flag_ce, flag_ue}), 32'h1);
                    check(rd_fixed == bad[15:0], "R5", "double error data untouched",
                          32'(rd_fixed), 32'(bad[15:0]));
                end
            end
        end
    endtask

    task automatic device_pass(input logic [23:0] good, input int lo, input int width,
                               input bit wide, input bit corr);
        logic [23:0] bad;
        for (int v = 1; v < (1 << width); v++) begin
            bad = good ^ (24'(v) << lo);
            present(bad, wide, corr);
            check(syndrome != '0 && (flag_ce || flag_ue), "R7", "device error detected",
                  32'({syndrome, flag_ce, flag_ue}), 32'h1);
            if (!corr)
                check(rd_fixed == bad[15:0], "R6", "detect mode raw on device error",
                      32'(rd_fixed), 32'(bad[15:0]));
        end
    endtask

    task automatic t_device(input bit wide, input bit corr);
        logic [7:0]  c;
        logic [23:0] good;
        for (int k = 1; k < 3; k++) begin
            encode(pats[k], wide, c);
            good = {c, pats[k]};
            for (int n = 0; n < 6; n++)
                device_pass(good, 4 * n, (!wide && n == 5) ? 2 : 4, wide, corr);
            if (wide)
                for (int y = 0; y < 3; y++)
                    device_pass(good, 8 * y, 8, wide, corr);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R9 watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_clean();
        t_ignore_upper();
        t_latency();
        for (int w = 0; w < 2; w++) begin
            for (int m = 0; m < 2; m++) begin
                t_single(w[0], m[0]);
                t_double(w[0], m[0]);
                t_device(w[0], m[0]);
            end
        end
        finish_run();
    end

endmodule